// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose command and data phases are split by a fixed two-cycle pipeline. Every rising clock edge samples one command. The command is a load read, a load write, a burst step, a deselect or an idle step. The data that belongs to a command crosses the bus two edges later. A controller can therefore issue a new command on every edge and mix reads and writes freely, with no idle cycles on the bus when the direction changes.

A word is 36 bits wide and is split into four byte lanes. Each lane has its own parity bit and its own active-low write enable. A burst counter steps through an aligned group of four words. A burst takes its direction from the cycle that loaded its start address. Three chip enables qualify a load. An active-low clock enable freezes the whole block for the edges where it is high. The bidirectional data bus is presented as separate input, output and output-enable ports.

Top module: `zbt_sram`

## Requirements
- R1: When `cen_n` is high at an edge, that edge changes nothing. The pipeline, the burst counter, `dout` and `dout_oe` keep their values, and no memory word is written.
- R2: The chip counts as selected only when `ce1_n` is 0, `ce2_n` is 0 and `ce3` is 1. A cycle with `adv_ld` low and any of these three false is a deselect: it starts no access and writes no memory.
- R3: A load read (`adv_ld` 0, selected, `rnw` 1) at edge k drives the addressed word on `dout`, with `dout_oe` at 1, from edge k+1 until edge k+2. In every other cycle `dout_oe` is 0.
- R4: A load write (`adv_ld` 0, selected, `rnw` 0) at edge k writes `din`, as sampled at edge k+2. Only lanes whose `be_n` bit was 0 at edge k are written. Lane j is `din[8j+7:8j]` together with parity bit `din[32+j]`. If `be_n` is 4'b1111 nothing is written. `be_n` has no effect on reads.
- R5: With `adv_ld` high after a load, the access uses the previous address with its two low bits incremented modulo 4 and the upper bits unchanged. The direction is the one set at the load. `rnw` and the chip enables are ignored on that cycle.
- R6: After a deselect at edge k, `dout_oe` is 0 from edge k+2, as long as the block is not suspended in between.
- R7: `adv_ld` high after a deselect, or after reset, is an idle step. It drives nothing and writes nothing.
- R8: A read of an address that has a write still in the pipeline returns the word with that write's enabled lanes already merged in. This holds for a read issued on the edge right after the write.
- R9: An edge with `rst` high clears every pending command and the burst state, and leaves `dout_oe` at 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Active-low clock enable; high suspends the block |
| ce1_n | input | 1 | Active-low chip enable |
| ce2_n | input | 1 | Second active-low chip enable |
| ce3 | input | 1 | Active-high chip enable |
| adv_ld | input | 1 | 0 loads an external address, 1 advances the burst |
| rnw | input | 1 | Direction at a load: 1 read, 0 write |
| addr | input | ADDR_W | Word address used at a load |
| be_n | input | 4 | Active-low byte-lane write enables |
| din | input | 36 | Write data from the bus, sampled two edges after its command |
| dout | output | 36 | Read data driven to the bus |
| dout_oe | output | 1 | High when `dout` should drive the bus |

## Verification
On every clock the assertions check that a suspended edge leaves the bus outputs unchanged. They check that `dout_oe` follows whether the command in the middle pipeline stage is a read, that deselect and idle steps lead to a released bus, and that reset releases the bus. The data itself can only be checked by the bench's scenarios against its behavioural memory. These scenarios cover byte-lane merging, burst wrap within a group of four, the direction kept through a burst, forwarding on back-to-back read after write, and writes that are held off by suspend or by a failed chip select.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    localparam int LANES      = 4;
    localparam int BYTE_W     = 8;
    localparam int LANE_W     = BYTE_W + 1;
    localparam int WORD_W     = LANES * LANE_W;
    localparam int PIPE_DEPTH = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ISS_IDLE  = 2'd0,
        ISS_LOAD  = 2'd1,
        ISS_STEP  = 2'd2,
        ISS_DESEL = 2'd3
    } iss_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] be_n;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{op: OP_NONE, be_n: '1};

    // lane j = parity bit at BYTE_W*LANES+j above byte j
    function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] w, input int j);
        return {w[LANES*BYTE_W + j], w[j*BYTE_W +: BYTE_W]};
    endfunction

endpackage

// File: rtl/zbt_issue.sv
`timescale 1ns/1ps
module zbt_issue import zbt_pkg::*; #(
    parameter int ADDR_W     = 6,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_n,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              live
);

    localparam logic [BURST_BITS-1:0] STEP_ONE = BURST_BITS'(1);

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] nxt;
    op_e               dir_q;
    logic              live_q;
    iss_e              kind;

    always_comb begin
        nxt = {cur_q[ADDR_W-1:BURST_BITS], cur_q[BURST_BITS-1:0] + STEP_ONE};
        if (!adv_ld) kind = sel ? ISS_LOAD : ISS_DESEL;
        else         kind = live_q ? ISS_STEP : ISS_IDLE;
    end

    always_comb begin
        cmd.be_n = be_n;
        cmd.op   = OP_NONE;
        cmd_addr = cur_q;
        case (kind)
            ISS_LOAD: begin
                cmd.op   = rnw ? OP_READ : OP_WRITE;
                cmd_addr = addr;
            end
            ISS_STEP: begin
                cmd.op   = dir_q;
                cmd_addr = nxt;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            dir_q  <= OP_NONE;
            live_q <= 1'b0;
        end else if (run) begin
            case (kind)
                ISS_LOAD: begin
                    cur_q  <= addr;
                    dir_q  <= rnw ? OP_READ : OP_WRITE;
                    live_q <= 1'b1;
                end
                ISS_STEP:  cur_q  <= nxt;
                ISS_DESEL: live_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign live = live_q;

endmodule

// File: rtl/zbt_pipe.sv
`timescale 1ns/1ps
module zbt_pipe import zbt_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  cmd_t              in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    output op_e               mid_op,
    output logic [ADDR_W-1:0] mid_addr,
    output cmd_t              tail_cmd,
    output logic [ADDR_W-1:0] tail_addr
);

    cmd_t              q_cmd  [PIPE_DEPTH];
    logic [ADDR_W-1:0] q_addr [PIPE_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_DEPTH; i++) begin
                q_cmd[i]  <= CMD_IDLE;
                q_addr[i] <= '0;
            end
        end else if (run) begin
            q_cmd[0]  <= in_cmd;
            q_addr[0] <= in_addr;
            for (int i = 1; i < PIPE_DEPTH; i++) begin
                q_cmd[i]  <= q_cmd[i-1];
                q_addr[i] <= q_addr[i-1];
            end
        end
    end

    assign mid_op    = q_cmd[PIPE_DEPTH-2].op;
    assign mid_addr  = q_addr[PIPE_DEPTH-2];
    assign tail_cmd  = q_cmd[PIPE_DEPTH-1];
    assign tail_addr = q_addr[PIPE_DEPTH-1];

endmodule

// File: rtl/zbt_store.sv
`timescale 1ns/1ps
module zbt_store import zbt_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = we && (waddr == raddr);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] wlane;
        logic [LANE_W-1:0] rlane;

        assign wlane = lane_of(wdata, j);

        always_ff @(posedge clk) begin
            if (we && !wbe_n[j]) mem_q[waddr] <= wlane;
        end

        // a write landing on this edge is returned to the read of the same word
        assign rlane = (hit && !wbe_n[j]) ? wlane : mem_q[raddr];

        assign rdata[j*BYTE_W +: BYTE_W]  = rlane[BYTE_W-1:0];
        assign rdata[LANES*BYTE_W + j]    = rlane[BYTE_W];
    end

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram import zbt_pkg::*; #(
    parameter int ADDR_W     = 6,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              ce3,
    input  logic              adv_ld,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);

    logic              run;
    logic              sel;
    cmd_t              iss_cmd;
    logic [ADDR_W-1:0] iss_addr;
    logic              burst_live;
    op_e               mid_op;
    logic [ADDR_W-1:0] mid_addr;
    cmd_t              tail_cmd;
    logic [ADDR_W-1:0] tail_addr;
    logic              commit;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] dout_q;
    logic              oe_q;

    assign run = !cen_n;
    assign sel = !ce1_n && !ce2_n && ce3;

    zbt_issue #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sel      (sel),
        .adv_ld   (adv_ld),
        .rnw      (rnw),
        .addr     (addr),
        .be_n     (be_n),
        .cmd      (iss_cmd),
        .cmd_addr (iss_addr),
        .live     (burst_live)
    );

    zbt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .in_cmd    (iss_cmd),
        .in_addr   (iss_addr),
        .mid_op    (mid_op),
        .mid_addr  (mid_addr),
        .tail_cmd  (tail_cmd),
        .tail_addr (tail_addr)
    );

    assign commit = run && (tail_cmd.op == OP_WRITE);

    zbt_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (commit),
        .waddr (tail_addr),
        .wbe_n (tail_cmd.be_n),
        .wdata (din),
        .raddr (mid_addr),
        .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else if (run) begin
            oe_q <= (mid_op == OP_READ);
            if (mid_op == OP_READ) dout_q <= rd_word;
        end
    end

    assign dout    = dout_q;
    assign dout_oe = oe_q;

endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk import zbt_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              cen_n,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              ce3,
    input logic              adv_ld,
    input logic [WORD_W-1:0] dout,
    input logic              dout_oe,
    input logic              burst_live,
    input op_e               mid_op
);

    logic port_sel;
    assign port_sel = !ce1_n && !ce2_n && ce3;

    AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(dout_oe) && $stable(dout))); // R1

    AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && mid_op == OP_READ) |=> dout_oe); // R3

    AST_NONREAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && mid_op != OP_READ) |=> !dout_oe); // R3

    AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && !port_sel) ##1 !cen_n |=> !dout_oe); // R6

    AST_IDLE_STEP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld && !burst_live) ##1 !cen_n |=> !dout_oe); // R7

    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> !dout_oe); // R9

endmodule

bind zbt_sram zbt_sram_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cen_n      (cen_n),
    .ce1_n      (ce1_n),
    .ce2_n      (ce2_n),
    .ce3        (ce3),
    .adv_ld     (adv_ld),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .burst_live (burst_live),
    .mid_op     (mid_op)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cen_n = 1'b0;
    logic          ce1_n = 1'b1;
    logic          ce2_n = 1'b0;
    logic          ce3 = 1'b1;
    logic          adv_ld = 1'b0;
    logic          rnw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    be_n = 4'hF;
    logic [35:0]   din = '0;
    logic [35:0]   dout;
    logic          dout_oe;

    always #2.5 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .BURST_BITS(2)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .cen_n   (cen_n),
        .ce1_n   (ce1_n),
        .ce2_n   (ce2_n),
        .ce3     (ce3),
        .adv_ld  (adv_ld),
        .rnw     (rnw),
        .addr    (addr),
        .be_n    (be_n),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    // ---------------- behavioural reference ----------------
    typedef struct {
        int         op;    // 0 none, 1 read, 2 write
        int         addr;
        logic [3:0] be;
    } pend_t;

    logic [35:0] m_mem [WORDS];
    pend_t       m_pipe [$];
    bit          m_live;
    int          m_cur;
    int          m_dir;
    bit          exp_oe;
    logic [35:0] exp_dout;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    function automatic pend_t idle_ent();
        pend_t e;
        e.op = 0; e.addr = 0; e.be = 4'hF;
        return e;
    endfunction

    function automatic void model_edge();
        pend_t tail, mid, nc;
        bit    s;
        if (rst) begin
            m_pipe.delete();
            m_pipe.push_back(idle_ent());
            m_pipe.push_back(idle_ent());
            exp_oe = 1'b0;
            m_live = 1'b0;
            return;
        end
        if (cen_n) return;
        tail = m_pipe[0];
        mid  = m_pipe[1];
        if (tail.op == 2) begin
            for (int j = 0; j < 4; j++) begin
                if (!tail.be[j]) begin
                    m_mem[tail.addr][j*8 +: 8] = din[j*8 +: 8];
                    m_mem[tail.addr][32+j]     = din[32+j];
                end
            end
        end
        exp_oe = (mid.op == 1);
        if (exp_oe) exp_dout = m_mem[mid.addr];
        nc = idle_ent();
        nc.be = be_n;
        s = !ce1_n && !ce2_n && ce3;
        if (!adv_ld) begin
            if (s) begin
                m_cur = int'(addr);
                m_dir = rnw ? 1 : 2;
                m_live = 1'b1;
                nc.op = m_dir;
                nc.addr = m_cur;
            end else begin
                m_live = 1'b0;
            end
        end else if (m_live) begin
            m_cur = (m_cur & ~3) | ((m_cur + 1) & 3);
            nc.op = m_dir;
            nc.addr = m_cur;
        end
        void'(m_pipe.pop_front());
        m_pipe.push_back(nc);
    endfunction

    // ---------------- stimulus ----------------
    task automatic cyc(input bit c_n, input bit e1, input bit e2, input bit e3,
                       input bit adv, input bit r, input int a, input logic [3:0] b,
                       input string tag);
        logic [63:0] rnd;
        rnd    = {$urandom(), $urandom()};
        cen_n  = c_n;
        ce1_n  = e1;
        ce2_n  = e2;
        ce3    = e3;
        adv_ld = adv;
        rnw    = r;
        addr   = AW'(a);
        be_n   = b;
        din    = rnd[35:0];
        @(posedge clk);
        model_edge();
        #1;
        n_chk++;
        if (dout_oe !== exp_oe) begin
            n_fail++;
            $display("FAIL %s: dout_oe=%0b expected %0b at %0t", tag, dout_oe, exp_oe, $time);
        end
        if (exp_oe) begin
            n_chk++;
            if (dout !== exp_dout) begin
                n_fail++;
                $display("FAIL %s: dout=%h expected %h at %0t", tag, dout, exp_dout, $time);
            end
        end
    endtask

    task automatic ld(input bit r, input int a, input logic [3:0] b, input string tag);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, r, a, b, tag);
    endtask

    task automatic bst(input bit r, input logic [3:0] b, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, r, 0, b, tag);
    endtask

    task automatic dsl(input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 4'hF, tag);
    endtask

    task automatic sus(input string tag);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7, 4'h0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_pipe.push_back(idle_ent());
        m_pipe.push_back(idle_ent());
        m_live = 1'b0; m_cur = 0; m_dir = 0;
        exp_oe = 1'b0; exp_dout = '0;

        // R9: reset state
        rst = 1'b1;
        repeat (3) dsl("R9");
        rst = 1'b0;
        bst(1'b1, 4'h0, "R7");          // idle step straight after reset
        dsl("R9");

        // R4/R5: fill memory with full-word write bursts; rnw high during steps is ignored
        for (int g = 0; g < WORDS/4; g++) begin
            ld(1'b0, g*4, 4'h0, "R4");
            repeat (3) bst(1'b1, 4'h0, "R5");
        end
        repeat (2) dsl("R4");

        // R3: single read and a wrapping read burst (6,7,4,5), be_n ignored on reads
        ld(1'b1, 5, 4'hF, "R3");
        repeat (3) dsl("R3");
        ld(1'b1, 6, 4'h0, "R4");
        repeat (3) bst(1'b0, 4'h0, "R5");
        repeat (3) dsl("R5");

        // R4: lane patterns, including no-write
        ld(1'b0, 9, 4'b1110, "R4");
        bst(1'b1, 4'b0101, "R4");
        bst(1'b1, 4'b1111, "R4");
        bst(1'b0, 4'b0110, "R4");
        repeat (2) dsl("R4");
        ld(1'b1, 8, 4'hF, "R4");
        repeat (3) bst(1'b0, 4'hF, "R4");
        repeat (3) dsl("R4");

        // R8: read right behind writes to the same word
        ld(1'b0, 12, 4'b0011, "R8");
        ld(1'b1, 12, 4'hF, "R8");
        ld(1'b0, 13, 4'h0, "R8");
        dsl("R8");
        ld(1'b1, 13, 4'hF, "R8");
        ld(1'b0, 14, 4'b1000, "R8");
        ld(1'b1, 14, 4'hF, "R8");
        ld(1'b0, 14, 4'b0001, "R8");
        ld(1'b1, 14, 4'hF, "R8");
        ld(1'b1, 14, 4'hF, "R8");
        repeat (3) dsl("R8");

        // R1: suspend holds bus, pipeline and pending write
        ld(1'b1, 20, 4'hF, "R1");
        repeat (2) sus("R1");
        dsl("R1");
        sus("R1");
        repeat (2) dsl("R1");
        ld(1'b0, 21, 4'h0, "R1");
        dsl("R1");
        repeat (3) sus("R1");
        dsl("R1");
        ld(1'b1, 21, 4'hF, "R1");
        repeat (3) dsl("R1");
        ld(1'b1, 22, 4'hF, "R1");
        bst(1'b1, 4'hF, "R1");
        repeat (3) sus("R1");
        bst(1'b1, 4'hF, "R1");
        repeat (3) dsl("R1");

        // R2: each enable false on its own blocks the access
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 30, 4'h0, "R2");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 30, 4'h0, "R2");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 30, 4'h0, "R2");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 31, 4'hF, "R2");
        repeat (2) dsl("R2");
        ld(1'b1, 30, 4'hF, "R2");
        repeat (3) dsl("R2");

        // R6: deselect right after a read burst
        ld(1'b1, 40, 4'hF, "R6");
        repeat (3) bst(1'b1, 4'hF, "R6");
        repeat (3) dsl("R6");

        // R7: steps after a deselect stay idle
        repeat (3) bst(1'b1, 4'hF, "R7");
        bst(1'b0, 4'h0, "R7");
        repeat (2) dsl("R7");
        ld(1'b1, 32, 4'hF, "R7");
        repeat (3) dsl("R7");

        // R9: reset with a read in flight
        ld(1'b1, 44, 4'hF, "R9");
        rst = 1'b1;
        dsl("R9");
        rst = 1'b0;
        bst(1'b1, 4'hF, "R9");
        repeat (3) dsl("R9");

        // mixed traffic
        for (int i = 0; i < 800; i++) begin
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0, 1, 2: ld(1'b1, $urandom_range(0, WORDS-1), 4'($urandom()), "R3");
                3, 4:    ld(1'b0, $urandom_range(0, WORDS-1), 4'($urandom()), "R8");
                5, 6:    bst(1'($urandom()), 4'($urandom()), "R5");
                7:       dsl("R6");
                8:       cyc(1'b0, 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'b0,
                             1'($urandom()), $urandom_range(0, WORDS-1), 4'($urandom()), "R2");
                default: sus("R1");
            endcase
        end
        repeat (3) dsl("R3");
        for (int a = 0; a < WORDS; a += 4) begin
            ld(1'b1, a, 4'hF, "R3");
            repeat (3) bst(1'b0, 4'h0, "R5");
        end
        repeat (3) dsl("R3");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule